// File: doc/BRIEF.md
# Broadcast Event Buffer with Snapshot

This block carries valued events from one producer to several consumers. The producer posts an event, with a data word, on any cycle it likes; it is never held off. The block keeps a single data word, so a newer post replaces an older word that nobody has read yet. Every consumer has its own pending flag, set by each post, so one consumer taking the event leaves the others' view untouched.

To make a consumer's reaction atomic, each consumer has two flag copies: a pending (active) flag that posts set, and a snapshot (frozen) flag that the consumer uses while it reacts. A freeze pulse at the start of a reaction moves the pending flag into the snapshot. A post arriving in the middle of a reaction only touches the pending flag, so it is kept for the next reaction. A take pulse clears the consumer's snapshot flag once it has used the event. Scheduling of consumers and any bus wrapper sit outside the block.

Top module: `evt_bcast_buf`

## Requirements
- R1: After reset (rst_n low, asynchronous), data_o is 0 and every bit of pend_o and snap_o is 0.
- R2: A post (post_i high at a rising edge) makes data_o equal to post_data_i from the next cycle; a later post overwrites the word even if no consumer took it.
- R3: A post sets every bit of pend_o from the next cycle, whatever the consumers are doing; there is no hold-off to the producer.
- R4: A freeze pulse on freeze_i[k] without a post copies pend_o[k] into snap_o[k] and clears pend_o[k] in the next cycle; flags of other consumers are unaffected.
- R5: When freeze_i[k] and post_i are high in the same cycle, snap_o[k] takes the old pend_o[k] and pend_o[k] is 1 in the next cycle, so the new event waits for the next reaction.
- R6: A take pulse on take_i[k] (without freeze_i[k]) clears snap_o[k] in the next cycle; pend_o, the other snap_o bits and data_o are unaffected.
- R7: When freeze_i[k] and take_i[k] are high in the same cycle, the freeze wins: snap_o[k] takes the old pend_o[k].
- R8: Without a post, data_o holds its value, whatever freeze and take pulses occur.
- R9: A pend_o bit never changes except by a post (sets it) or its own freeze (clears it).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| post_i | input | 1 | Producer posts an event this cycle |
| post_data_i | input | W | Data word carried by the event |
| freeze_i | input | N | Per-consumer snapshot pulse, bit k for consumer k |
| take_i | input | N | Per-consumer take pulse, clears that consumer's snapshot flag |
| data_o | output | W | Stored event word |
| pend_o | output | N | Per-consumer pending (active) flags |
| snap_o | output | N | Per-consumer snapshot (frozen) flags |

## Verification
Every output is a register, so the effect of a post, freeze or take sampled at one rising edge is visible from that edge until the next one, and no result is due in the same cycle as its stimulus. The bench drives inputs at the falling edge, predicts the state after the following rising edge in a behavioural model, and compares data_o, pend_o and snap_o at the next falling edge, one cycle after each stimulus. Directed steps hit the same-cycle collisions (post with freeze, freeze with take) and overwrite without a take, then a long pseudo-random run is compared every cycle.

// File: rtl/evb_pkg.sv
package evb_pkg;

  // Next pending flag: a post sets it, the consumer's own freeze clears it.
  function automatic logic pend_next(input logic cur, input logic post,
                                     input logic frz);
    return post | (cur & ~frz);
  endfunction

  // Next snapshot flag: a freeze loads the pending flag (wins over take),
  // otherwise a take clears it.
  function automatic logic snap_next(input logic cur, input logic pend,
                                     input logic frz, input logic take);
    logic r;
    if (frz) r = pend;
    else     r = cur & ~take;
    return r;
  endfunction

endpackage

// File: rtl/evb_word_reg.sv
module evb_word_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q_o <= '0;
    else if (load_i) q_o <= d_i;
  end

  p_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (q_o == $past(d_i)));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(q_o));

endmodule

// File: rtl/evb_flag_pair.sv
module evb_flag_pair
  import evb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic post_i,
  input  logic frz_i,
  input  logic take_i,
  output logic pend_o,
  output logic snap_o
);

  logic pend_d;
  logic snap_d;
  logic kept_evt;   // post arriving during a freeze: kept for next reaction

  assign pend_d   = pend_next(pend_o, post_i, frz_i);
  assign snap_d   = snap_next(snap_o, pend_o, frz_i, take_i);
  assign kept_evt = post_i & frz_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_o <= 1'b0;
      snap_o <= 1'b0;
    end else begin
      pend_o <= pend_d;
      snap_o <= snap_d;
    end
  end

  p_post_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    post_i |=> pend_o);

  p_freeze_copy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    frz_i |=> (snap_o == $past(pend_o)));

  p_freeze_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (frz_i && !post_i) |=> !pend_o);

  p_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    kept_evt |=> pend_o);

  p_take_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && !frz_i) |=> !snap_o);

  p_pend_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!post_i && !frz_i) |=> $stable(pend_o));

endmodule

// File: rtl/evt_bcast_buf.sv
module evt_bcast_buf #(
  parameter int N = 4,
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         post_i,
  input  logic [W-1:0] post_data_i,
  input  logic [N-1:0] freeze_i,
  input  logic [N-1:0] take_i,
  output logic [W-1:0] data_o,
  output logic [N-1:0] pend_o,
  output logic [N-1:0] snap_o
);

  logic post_evt;
  assign post_evt = post_i;

  evb_word_reg #(.W(W)) u_word (
    .clk   (clk),
    .rst_n (rst_n),
    .load_i(post_evt),
    .d_i   (post_data_i),
    .q_o   (data_o)
  );

  for (genvar k = 0; k < N; k++) begin : g_cons
    evb_flag_pair u_flags (
      .clk   (clk),
      .rst_n (rst_n),
      .post_i(post_evt),
      .frz_i (freeze_i[k]),
      .take_i(take_i[k]),
      .pend_o(pend_o[k]),
      .snap_o(snap_o[k])
    );
  end

  p_reset_r1: assert property (@(posedge clk)
    !rst_n |=> (data_o == '0 || post_evt));

  p_fanout_r3: assert property (@(posedge clk) disable iff (!rst_n)
    post_evt |=> (&pend_o));

endmodule

// File: tb/evt_bcast_buf_test.sv
module evt_bcast_buf_test;
  localparam int N = 4;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         post_i = 1'b0;
  logic [W-1:0] post_data_i = '0;
  logic [N-1:0] freeze_i = '0;
  logic [N-1:0] take_i = '0;
  logic [W-1:0] data_o;
  logic [N-1:0] pend_o;
  logic [N-1:0] snap_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // behavioural model state
  int m_data;
  bit m_pend [N];
  bit m_snap [N];

  always #5 clk = ~clk;

  evt_bcast_buf #(.N(N), .W(W)) uut (
    .clk(clk), .rst_n(rst_n), .post_i(post_i), .post_data_i(post_data_i),
    .freeze_i(freeze_i), .take_i(take_i),
    .data_o(data_o), .pend_o(pend_o), .snap_o(snap_o)
  );

  function automatic logic [N-1:0] pack(input bit a [N]);
    logic [N-1:0] v;
    for (int k = 0; k < N; k++) v[k] = a[k];
    return v;
  endfunction

  task automatic compare(input string tag);
    logic [N-1:0] ep, es;
    ep = pack(m_pend);
    es = pack(m_snap);
    checks++;
    if (data_o !== W'(m_data)) begin
      fails++;
      $display("FAIL %s data_o: got %0h expected %0h", tag, data_o, W'(m_data));
    end
    checks++;
    if (pend_o !== ep) begin
      fails++;
      $display("FAIL %s pend_o: got %b expected %b", tag, pend_o, ep);
    end
    checks++;
    if (snap_o !== es) begin
      fails++;
      $display("FAIL %s snap_o: got %b expected %b", tag, snap_o, es);
    end
  endtask

  // Drive one cycle at the falling edge, predict, compare one cycle later.
  task automatic step(input bit p, input int d, input logic [N-1:0] f,
                      input logic [N-1:0] t, input string tag);
    post_i = p; post_data_i = W'(d); freeze_i = f; take_i = t;
    if (p) m_data = d % (1 << W);
    for (int k = 0; k < N; k++) begin
      bit old_pend;
      old_pend = m_pend[k];
      if (f[k])      m_snap[k] = old_pend;
      else if (t[k]) m_snap[k] = 0;
      if (p)         m_pend[k] = 1;
      else if (f[k]) m_pend[k] = 0;
    end
    @(negedge clk);
    compare(tag);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin : main
    int seed;
    m_data = 0;
    for (int k = 0; k < N; k++) begin m_pend[k] = 0; m_snap[k] = 0; end
    repeat (3) @(negedge clk);
    compare("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1 after release");

    step(1, 8'h5A, '0, '0, "R2 R3 first post");
    step(1, 8'hA5, '0, '0, "R2 overwrite");
    step(0, 8'hFF, 4'b0010, '0, "R4 freeze cons1");
    step(0, 8'h11, 4'b0010, '0, "R4 refreeze empty");
    step(1, 8'h3C, 4'b0100, '0, "R5 post with freeze");
    step(0, 8'h00, '0, 4'b0100, "R6 take cons2");
    step(0, 8'h00, '0, 4'b0100, "R6 take again");
    step(0, 8'h00, 4'b0001, 4'b0001, "R7 freeze beats take");
    step(0, 8'h77, '0, 4'b1111, "R8 no post holds data");
    step(0, 8'h77, '0, '0, "R9 idle keeps pend");
    step(1, 8'hC3, 4'b1111, 4'b1111, "R5 all freeze with post");
    step(0, 8'h00, 4'b1111, '0, "R4 all freeze");
    step(1, 8'h01, '0, 4'b1010, "R3 post during take");

    seed = 7;
    for (int i = 0; i < 400; i++) begin
      int r;
      r = $urandom(seed + i);
      step(r[0], int'(r[15:8]), r[19:16] & {N{r[1]}},
           r[23:20] & {N{r[2]}}, "random R2 R4 R6 R9");
    end

    rst_n = 1'b0;
    m_data = 0;
    for (int k = 0; k < N; k++) begin m_pend[k] = 0; m_snap[k] = 0; end
    post_i = 1'b0; freeze_i = '0; take_i = '0;
    #1;
    compare("R1 async reset");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

endmodule